// File: doc/BRIEF.md
# Reseed Conditioner for a Deterministic Random Bit Generator

This block turns seed material into the 64-bit internal state of a deterministic random bit generator. On each reseed it runs an FNV-1a hash one byte per clock: first over the bytes of one chosen seed source, then over a 384-bit personalization block. The source is one of four, taken in strict priority. The first is a 48-byte external seed. The second is a 128-bit test register that is filled one bit per write. The third is a nonzero forced seed paired with a reseed event counter. The last is a fallback entropy word supplied on a port.

A reseed begins either on a `start_i` pulse or on a test-bit write made in test mode. A test-bit write also consumes one generation at once. While the hash runs, `busy_o` is high. When it finishes, `done_o` pulses for one cycle and, in that same cycle, the new state appears on `state_o`. At that point the generation budget reloads and a pulse tells the downstream output buffer to drop its stored words. The consumer of the state lowers the budget one generation at a time through `gen_take_i`.

Top module: `reseed_conditioner`

## Requirements
- R1: The hash accumulator is cleared when a reseed starts. For each byte b it becomes (acc XOR b) * 0x100000001B3 modulo 2^64. `state_o` shows the final accumulator from the `done_o` cycle onward.
- R2: The source is chosen when the reseed starts, in this priority: the external seed if `ext_sel_i` is 1; otherwise the test register if `test_mode_i` is 1; otherwise the forced seed if `forced_seed_i` is nonzero; otherwise `entropy_i`.
- R3: The external seed is hashed as 48 bytes, least significant byte first (byte k is bits [8k+7:8k]). The personalization block `pers_i` then follows in the same byte order.
- R4: When `pers_dis_i` is 1 at the start, 48 zero bytes are hashed in place of `pers_i`.
- R5: A 64-bit forced-event counter is 0 after reset and increments when a forced-source reseed starts. The hash takes the incremented counter, then the forced seed, each as 8 bytes with the least significant byte first.
- R6: In test mode a `test_bit_we_i` pulse while idle shifts `test_bit_i` into bit 0 of a 128-bit register; bit 63 moves into bit 64. The pulse also starts a reseed, which hashes the register as 16 bytes with the least significant byte first, and the budget then loads 2^48 - 1.
- R7: The entropy source is hashed as the 8 bytes of `entropy_i`, least significant first, followed by 8 zero bytes.
- R8: `busy_o` stays high for exactly 64 cycles with a 16-byte source and 96 cycles with the external seed. `done_o` is high for exactly the one cycle after `busy_o` falls.
- R9: A reseed started by `start_i` loads the budget with 2^48, and `words_clr_o` pulses together with `done_o`. Each cycle in which `gen_take_i` is high and the budget is nonzero lowers the budget by one. A zero budget stays at zero.
- R10: `start_i` and `test_bit_we_i` pulses that arrive while `busy_o` is high have no effect: no extra reseed, no shift of the test register, and no count of the forced counter.
- R11: After reset `busy_o`, `done_o`, `words_clr_o`, `state_o` and `budget_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Requests a reseed when idle |
| ext_sel_i | input | 1 | Selects the external seed source |
| test_mode_i | input | 1 | Enables the test-register source and bit writes |
| pers_dis_i | input | 1 | Replaces the personalization block with zeros |
| ext_seed_i | input | 384 | External seed, held stable while busy |
| pers_i | input | 384 | Personalization block, held stable while busy |
| forced_seed_i | input | 64 | Forced deterministic seed, held stable while busy |
| entropy_i | input | 64 | Fallback entropy word, held stable while busy |
| test_bit_we_i | input | 1 | Test-bit write strobe |
| test_bit_i | input | 1 | Bit shifted into the test register |
| gen_take_i | input | 1 | Consumes one generation from the budget |
| busy_o | output | 1 | Hash in progress |
| done_o | output | 1 | One-cycle completion pulse |
| words_clr_o | output | 1 | Tells the output buffer to drop stored words |
| state_o | output | 64 | Generator state produced by the last reseed |
| budget_o | output | 49 | Remaining generations |

## Verification
Every reseed result comes from an independent byte-wise FNV-1a model that is scored against the design's done events. The external seed is run once with ones on all the lower-priority controls, which proves that it wins, and once with personalization disabled, which shows whether zero bytes are really substituted. Back-to-back forced reseeds with the same seed should give different states, and that exposes the counter's increment and its byte order. A long run of test-bit writes passes the 64-bit boundary, so a missing carry into the upper word would show in the hashed value. Start and test-bit pulses during a busy reseed are caught by the done count and by the values of later reseeds.

// File: rtl/rc_pkg.sv
package rc_pkg;
   typedef enum logic [1:0] {
      SRC_EXT     = 2'd0,
      SRC_TEST    = 2'd1,
      SRC_FORCED  = 2'd2,
      SRC_ENTROPY = 2'd3
   } rc_src_e;
endpackage

// File: rtl/rc_fnv_acc.sv
module rc_fnv_acc #(
   parameter int          HASH_W = 64,
   parameter logic [63:0] PRIME  = 64'h0000_0100_0000_01B3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              en_i,
   input  logic [7:0]        byte_i,
   output logic [HASH_W-1:0] acc_o,
   output logic [HASH_W-1:0] acc_next_o
);
   logic [HASH_W-1:0] acc_q;

   generate
      if (HASH_W < 8 || HASH_W > 64) begin : g_bad_width
         $error("rc_fnv_acc: HASH_W must lie in 8..64");
      end
   endgenerate

   assign acc_next_o = (acc_q ^ HASH_W'(byte_i)) * PRIME[HASH_W-1:0];
   assign acc_o      = acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc_q <= '0;
      else if (clr_i) acc_q <= '0;
      else if (en_i)  acc_q <= acc_next_o;
   end

   // R1: accumulator only moves while absorbing or clearing
   p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !en_i) |=> $stable(acc_q));
endmodule

// File: rtl/rc_test_shreg.sv
module rc_test_shreg #(
   parameter int WIDTH = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_i,
   input  logic             bit_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] q;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("rc_test_shreg: WIDTH must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (shift_i) q <= {q[WIDTH-2:0], bit_i};
   end

   assign q_o = q;

   // R6: the written bit lands in the LSB
   p_shift_lsb_r6: assert property (@(posedge clk) disable iff (!rst_n)
      shift_i |=> (q[0] == $past(bit_i)));
   // R10: no shift means no change
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_i |=> $stable(q));
endmodule

// File: rtl/rc_budget.sv
module rc_budget #(
   parameter int LOG2_MAX = 48
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic            minus_one_i,
   input  logic            take_i,
   output logic [LOG2_MAX:0] q_o
);
   localparam int CW = LOG2_MAX + 1;
   localparam logic [CW-1:0] FULL = CW'(1) << LOG2_MAX;

   logic [CW-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      q <= '0;
      else if (load_i)                 q <= minus_one_i ? FULL - CW'(1) : FULL;
      else if (take_i && q != '0)      q <= q - CW'(1);
   end

   assign q_o = q;

   // R9: without a load the budget never rises
   p_no_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load_i) |-> (q <= $past(q)));
   // R9: empty budget stays empty
   p_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (q == '0 && !load_i) |=> (q == '0));
endmodule

// File: rtl/reseed_conditioner.sv
module reseed_conditioner
   import rc_pkg::*;
#(
   parameter int          SEED_BYTES = 48,
   parameter int          WORD_W     = 64,
   parameter int          TEST_W     = 128,
   parameter int          BUDGET_LOG = 48,
   parameter logic [63:0] FNV_PRIME  = 64'h0000_0100_0000_01B3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic                  ext_sel_i,
   input  logic                  test_mode_i,
   input  logic                  pers_dis_i,
   input  logic [383:0]          ext_seed_i,
   input  logic [383:0]          pers_i,
   input  logic [63:0]           forced_seed_i,
   input  logic [63:0]           entropy_i,
   input  logic                  test_bit_we_i,
   input  logic                  test_bit_i,
   input  logic                  gen_take_i,
   output logic                  busy_o,
   output logic                  done_o,
   output logic                  words_clr_o,
   output logic [63:0]           state_o,
   output logic [48:0]           budget_o
);
   localparam int SEED_W      = SEED_BYTES * 8;
   localparam int SHORT_BYTES = TEST_W / 8;
   localparam int IDX_W       = $clog2(SEED_BYTES);
   localparam int PAD_W       = SEED_W - TEST_W;
   localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(SEED_BYTES - 1);
   localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(SHORT_BYTES - 1);
   localparam logic [BUDGET_LOG:0] FULL_BUDGET = (BUDGET_LOG+1)'(1) << BUDGET_LOG;

   generate
      if (SEED_W != 384 || WORD_W != 64 || BUDGET_LOG != 48) begin : g_bad_port_fit
         $error("reseed_conditioner: parameters must match the port widths");
      end
      if (TEST_W != 2 * WORD_W) begin : g_bad_test_w
         $error("reseed_conditioner: TEST_W must hold exactly two words");
      end
      if (SHORT_BYTES > SEED_BYTES) begin : g_bad_short
         $error("reseed_conditioner: short source longer than seed bank");
      end
   endgenerate

   // ---------------- control state ----------------
   logic              busy_q, done_q, pers_phase_q, pdis_q, test_trig_q;
   logic [IDX_W-1:0]  idx_q;
   rc_src_e           src_q, src_pick;
   logic [WORD_W-1:0] fcnt_q;
   logic [WORD_W-1:0] state_q;

   logic test_wr, trig, fcnt_inc, last_src_byte, finish;
   logic [TEST_W-1:0] tst_q;
   logic [SEED_W-1:0] src_blk;
   logic [7:0]        cur_byte;
   logic [WORD_W-1:0] acc_q, acc_next;
   logic [8+IDX_W-1:0] bit_off;

   assign test_wr  = test_bit_we_i && test_mode_i && !busy_q;
   assign trig     = !busy_q && (start_i || test_wr);

   always_comb begin
      if (ext_sel_i)                 src_pick = SRC_EXT;
      else if (test_mode_i)          src_pick = SRC_TEST;
      else if (forced_seed_i != '0)  src_pick = SRC_FORCED;
      else                           src_pick = SRC_ENTROPY;
   end

   assign fcnt_inc = trig && (src_pick == SRC_FORCED);

   // ---------------- source block and byte pick ----------------
   always_comb begin
      unique case (src_q)
         SRC_EXT:     src_blk = ext_seed_i;
         SRC_TEST:    src_blk = {{PAD_W{1'b0}}, tst_q};
         SRC_FORCED:  src_blk = {{PAD_W{1'b0}}, forced_seed_i, fcnt_q};
         default:     src_blk = {{PAD_W{1'b0}}, {WORD_W{1'b0}}, entropy_i};
      endcase
   end

   assign bit_off = {idx_q, 3'b000};

   always_comb begin
      if (!pers_phase_q)  cur_byte = src_blk[bit_off +: 8];
      else if (pdis_q)    cur_byte = 8'h00;
      else                cur_byte = pers_i[bit_off +: 8];
   end

   assign last_src_byte = !pers_phase_q &&
                          (idx_q == ((src_q == SRC_EXT) ? LAST_LONG : LAST_SHORT));
   assign finish        = busy_q && pers_phase_q && (idx_q == LAST_LONG);

   // ---------------- sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q       <= 1'b0;
         done_q       <= 1'b0;
         pers_phase_q <= 1'b0;
         pdis_q       <= 1'b0;
         test_trig_q  <= 1'b0;
         idx_q        <= '0;
         src_q        <= SRC_EXT;
         fcnt_q       <= '0;
         state_q      <= '0;
      end else begin
         done_q <= 1'b0;
         if (fcnt_inc) fcnt_q <= fcnt_q + WORD_W'(1);
         if (trig) begin
            busy_q       <= 1'b1;
            pers_phase_q <= 1'b0;
            idx_q        <= '0;
            src_q        <= src_pick;
            pdis_q       <= pers_dis_i;
            test_trig_q  <= test_wr;
         end else if (busy_q) begin
            if (finish) begin
               busy_q  <= 1'b0;
               done_q  <= 1'b1;
               state_q <= acc_next;
            end else if (last_src_byte) begin
               pers_phase_q <= 1'b1;
               idx_q        <= '0;
            end else begin
               idx_q <= idx_q + IDX_W'(1);
            end
         end
      end
   end

   // ---------------- sub-blocks ----------------
   rc_fnv_acc #(.HASH_W(WORD_W), .PRIME(FNV_PRIME)) u_hash (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (trig),
      .en_i       (busy_q),
      .byte_i     (cur_byte),
      .acc_o      (acc_q),
      .acc_next_o (acc_next)
   );

   rc_test_shreg #(.WIDTH(TEST_W)) u_tst (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_i (test_wr),
      .bit_i   (test_bit_i),
      .q_o     (tst_q)
   );

   rc_budget #(.LOG2_MAX(BUDGET_LOG)) u_budget (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (finish),
      .minus_one_i (test_trig_q),
      .take_i      (gen_take_i),
      .q_o         (budget_o)
   );

   assign busy_o      = busy_q;
   assign done_o      = done_q;
   assign words_clr_o = done_q;
   assign state_o     = state_q;

   // ---------------- assertions ----------------
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   p_busy_ends_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);
   p_budget_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (budget_o == FULL_BUDGET || budget_o == FULL_BUDGET - 49'd1));
   p_src_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(src_q));
   p_fcnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fcnt_inc |=> (fcnt_q == $past(fcnt_q) + WORD_W'(1)));
   p_fcnt_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> $stable(fcnt_q));
   p_hash_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> (acc_q == '0));
endmodule

// File: tb/reseed_conditioner_tb_top.sv
`timescale 1ns/1ps
module reseed_conditioner_tb_top;
   localparam logic [63:0] PRIME = 64'h0000_0100_0000_01B3;
   localparam logic [48:0] FULL  = 49'h1_0000_0000_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 0, ext_sel_i = 0, test_mode_i = 0, pers_dis_i = 0;
   logic [383:0] ext_seed_i = '0, pers_i = '0;
   logic [63:0] forced_seed_i = '0, entropy_i = '0;
   logic test_bit_we_i = 0, test_bit_i = 0, gen_take_i = 0;
   logic busy_o, done_o, words_clr_o;
   logic [63:0] state_o;
   logic [48:0] budget_o;

   always #2.5 clk = ~clk;

   reseed_conditioner dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .ext_sel_i(ext_sel_i),
      .test_mode_i(test_mode_i), .pers_dis_i(pers_dis_i), .ext_seed_i(ext_seed_i),
      .pers_i(pers_i), .forced_seed_i(forced_seed_i), .entropy_i(entropy_i),
      .test_bit_we_i(test_bit_we_i), .test_bit_i(test_bit_i), .gen_take_i(gen_take_i),
      .busy_o(busy_o), .done_o(done_o), .words_clr_o(words_clr_o),
      .state_o(state_o), .budget_o(budget_o)
   );

   typedef struct {
      logic [63:0] state;
      logic [48:0] budget;
      string       tag;
   } exp_t;

   exp_t        sb_q[$];
   int          n_checks = 0;
   int          n_errors = 0;
   int          n_done   = 0;
   logic [63:0] m_fcnt   = '0;
   logic [127:0] m_tst   = '0;
   bit          finished = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] ref_hash(input logic [383:0] src, input int nbytes,
                                            input logic [383:0] pers, input bit pdis);
      logic [63:0] h = '0;
      for (int i = 0; i < nbytes; i++) h = (h ^ {56'd0, src[i*8 +: 8]}) * PRIME;
      for (int i = 0; i < 48; i++)
         h = (h ^ {56'd0, (pdis ? 8'h00 : pers[i*8 +: 8])}) * PRIME;
      return h;
   endfunction

   // monitor: pops the scoreboard on every completion
   always @(negedge clk) begin
      if (rst_n && done_o && !finished) begin
         n_done++;
         if (sb_q.size() == 0) begin
            check(0, "R10", "unexpected done", 64'd1, 64'd0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            check(state_o == e.state, e.tag, "state", state_o, e.state);
            check(budget_o == e.budget, "R9", "budget at done", {15'd0, budget_o}, {15'd0, e.budget});
            check(words_clr_o == 1'b1, "R9", "word clear pulse", {63'd0, words_clr_o}, 64'd1);
         end
      end
   end

   // wait for completion, counting busy cycles
   task automatic wait_done(input int exp_cyc, input string req);
      int cyc = 0;
      while (!done_o) begin
         if (busy_o) cyc++;
         @(negedge clk);
      end
      check(cyc == exp_cyc, "R8", {req, " busy length"}, 64'(cyc), 64'(exp_cyc));
      @(negedge clk);
      check(done_o == 1'b0, "R8", "done width", {63'd0, done_o}, 64'd0);
   endtask

   // driver for start-triggered reseeds; the source is predicted from R2
   task automatic do_start(input string req, input bit poke_busy);
      exp_t e;
      logic [383:0] src;
      int n;
      if (ext_sel_i) begin src = ext_seed_i; n = 48; end
      else if (test_mode_i) begin src = {256'd0, m_tst}; n = 16; end
      else if (forced_seed_i != 0) begin
         m_fcnt = m_fcnt + 1;
         src = {256'd0, forced_seed_i, m_fcnt}; n = 16;
      end else begin src = {256'd0, 64'd0, entropy_i}; n = 16; end
      e.state  = ref_hash(src, n, pers_i, pers_dis_i);
      e.budget = FULL;
      e.tag    = req;
      sb_q.push_back(e);
      @(negedge clk); start_i = 1;
      @(negedge clk); start_i = 0;
      if (poke_busy) begin
         // R10: start and test-bit pulses while busy must be ignored
         repeat (10) @(negedge clk);
         start_i = 1; test_bit_we_i = 1; test_bit_i = 1;
         @(negedge clk);
         start_i = 0; test_bit_we_i = 0; test_bit_i = 0;
         wait_done(n == 48 ? 96 : 64 - 11, req);
      end else begin
         wait_done(n == 48 ? 96 : 64, req);
      end
   endtask

   // driver for test-bit writes (R6)
   task automatic do_test_bit(input bit b);
      exp_t e;
      m_tst    = {m_tst[126:0], b};
      e.state  = ref_hash({256'd0, m_tst}, 16, pers_i, pers_dis_i);
      e.budget = FULL - 49'd1;
      e.tag    = "R6";
      sb_q.push_back(e);
      @(negedge clk); test_bit_we_i = 1; test_bit_i = b;
      @(negedge clk); test_bit_we_i = 0; test_bit_i = 0;
      wait_done(64, "R6");
   endtask

   initial begin
      #(5.0 * 200000);
      check(0, "R8", "watchdog expired", 64'd0, 64'd1);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      int done_before;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11 reset state
      check(busy_o == 0, "R11", "busy after reset", {63'd0, busy_o}, 64'd0);
      check(done_o == 0, "R11", "done after reset", {63'd0, done_o}, 64'd0);
      check(state_o == 0, "R11", "state after reset", state_o, 64'd0);
      check(budget_o == 0, "R11", "budget after reset", {15'd0, budget_o}, 64'd0);
      // R9: empty budget stays at zero
      gen_take_i = 1; repeat (3) @(negedge clk); gen_take_i = 0;
      check(budget_o == 0, "R9", "empty budget floor", {15'd0, budget_o}, 64'd0);

      pers_i = {6{64'hA5C3_0F1E_7788_9911}} ^ {48{8'h3C}};
      pers_i[7:0] = 8'h01;
      // R2/R3: external seed wins over every other control
      ext_seed_i = {12{32'hDEAD_BEEF}} ^ {384'h1234_5678_9ABC_DEF0};
      ext_sel_i = 1; test_mode_i = 1; forced_seed_i = 64'h55; entropy_i = 64'h77;
      do_start("R3", 0);
      // R4: personalization disabled
      pers_dis_i = 1;
      do_start("R4", 0);
      pers_dis_i = 0;

      // R5: forced source, consecutive reseeds see counter 1 then 2
      ext_sel_i = 0; test_mode_i = 0;
      forced_seed_i = 64'h0123_4567_89AB_CDEF;
      do_start("R5", 0);
      do_start("R5", 0);
      // R10: pokes during busy; the counter must only have stepped once
      done_before = n_done;
      do_start("R10", 1);
      check(n_done == done_before + 1, "R10", "single completion", 64'(n_done), 64'(done_before + 1));
      do_start("R5", 0);

      // R7: fallback entropy
      forced_seed_i = 64'd0; entropy_i = 64'hFEED_FACE_CAFE_0042;
      do_start("R7", 0);
      check(sb_q.size() == 0, "R10", "no extra completion", 64'(sb_q.size()), 64'd0);

      // R9: budget decrement by gen_take
      @(negedge clk); gen_take_i = 1;
      repeat (5) @(negedge clk);
      gen_take_i = 0;
      check(budget_o == FULL - 49'd5, "R9", "budget after takes",
            {15'd0, budget_o}, {15'd0, FULL - 49'd5});

      // R6: test-bit writes, enough to carry across bit 63
      test_mode_i = 1;
      for (int k = 0; k < 70; k++) do_test_bit(((k * 7) % 3) == 1);
      // R2: test source by start when external not selected
      do_start("R2", 0);

      repeat (4) @(negedge clk);
      check(sb_q.size() == 0, "R10", "scoreboard drained", 64'(sb_q.size()), 64'd0);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule